// File: doc/BRIEF.md
# Schedule Base-Time Future Adjuster

This block moves a requested schedule start time forward so that it lies safely in the future while keeping the schedule's phase. It takes a requested base time, a cycle time and the present clock time. If the request is already far enough ahead, the block returns it as is. Otherwise it returns the request plus the smallest whole number of cycles that reaches a threshold of two cycle times past the present clock time.

The search uses no divider. After an accepted `start`, the block first doubles a chunk, which is the cycle time times a power of two, until the chunk covers the gap between the base and the threshold. It then walks back down through the powers of two. At each level it adds the chunk to a running value if the sum stays below the threshold. This leaves the largest cycle-aligned value below the threshold, and one more cycle is added to it. Each step takes one clock. The caller sees `busy` while a job runs, then a one-clock `done`, and reads `result` and `err`. Both stay valid until the next accepted start. Times are unsigned nanosecond counts that are assumed not to wrap.

Top module: `sched_base_adjust`

## Requirements
- R1: On an adjusted job the threshold is `now_in + 2*cycle_in`, taken at the accepted start. The result satisfies threshold <= result < threshold + cycle.
- R2: If `cycle_in` is nonzero and `base_in` >= threshold, then `result` equals `base_in` and `err` is 0. `done` is high in the clock right after the start edge.
- R3: If `base_in` < threshold, then `result` = `base_in` + N*`cycle_in`, where N is the smallest count that puts the result at or above the threshold.
- R4: If `cycle_in` is zero, `err` is 1 and `result` equals `base_in`, whatever `now_in` is. `done` is high in the clock right after the start edge. This case wins over the R2 case.
- R5: `done` is high for exactly one clock per accepted job. `result` and `err` keep their values until the next accepted start.
- R6: The block accepts `start` only while `busy` is 0. A start that arrives while `busy` is 1, including the clock in which `done` is high, changes neither `result` nor `err` and starts no job.
- R7: After reset, `busy`, `done` and `err` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job with the three operands below (accepted when not busy) |
| base_in | input | TIME_W | Requested schedule base time |
| cycle_in | input | CYC_W | Schedule cycle time |
| now_in | input | TIME_W | Present clock time |
| busy | output | 1 | Job in progress or completing (start is ignored) |
| done | output | 1 | One-clock pulse: result and err are valid |
| err | output | 1 | Cycle time was zero for the last job |
| result | output | TIME_W | Adjusted base time |

## Verification
Two functions can apply to the same job. The zero-cycle error check and the already-in-future pass-through both hold when the cycle is zero and the base is at or after the present time, because the threshold then equals the present time. The bench drives exactly that operand set and expects `err` set, with the base returned in the clock after the start edge. In a second overlap, a new start arrives in the very clock in which `done` pulses. The bench judges that start ignored when the following clocks show `done` low, `busy` low, and `result` and `err` unchanged from the finished job.

// File: rtl/baseadj_pkg.sv
package baseadj_pkg;
  parameter int TIME_W_DEF = 64;
  parameter int CYC_W_DEF  = 32;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_GROW = 2'd1,
    S_DESC = 2'd2,
    S_DONE = 2'd3
  } adj_state_t;
endpackage

// File: rtl/baseadj_thresh.sv
module baseadj_thresh #(
  parameter int TIME_W = 64,
  parameter int CYC_W  = 32
) (
  input  logic [TIME_W-1:0] now_t,
  input  logic [TIME_W-1:0] base_t,
  input  logic [CYC_W-1:0]  cyc_t,
  output logic [TIME_W-1:0] thr_t,
  output logic [TIME_W-1:0] gap_t,
  output logic              in_future,
  output logic              zero_cyc
);
  function automatic logic [TIME_W-1:0] two_cycles_ahead(
    input logic [TIME_W-1:0] now_v, input logic [CYC_W-1:0] cyc_v);
    logic [TIME_W-1:0] dbl;
    dbl = TIME_W'({cyc_v, 1'b0});
    return now_v + dbl;
  endfunction

  always_comb begin
    thr_t     = two_cycles_ahead(now_t, cyc_t);
    in_future = (base_t >= thr_t);
    gap_t     = thr_t - base_t;
    zero_cyc  = (cyc_t == '0);
  end
endmodule

// File: rtl/baseadj_step.sv
module baseadj_step #(
  parameter int TIME_W = 64,
  parameter int CH_W   = 66
) (
  input  logic [TIME_W-1:0] run_v,
  input  logic [CH_W-1:0]   chunk_v,
  input  logic [TIME_W-1:0] thr_v,
  output logic [TIME_W-1:0] run_nxt,
  output logic              took
);
  function automatic logic fits_below(
    input logic [CH_W-1:0] sum_v, input logic [TIME_W-1:0] lim_v);
    return sum_v < CH_W'(lim_v);
  endfunction

  logic [CH_W-1:0] sum_w;

  always_comb begin
    sum_w   = CH_W'(run_v) + chunk_v;
    took    = fits_below(sum_w, thr_v);
    run_nxt = took ? sum_w[TIME_W-1:0] : run_v;
  end
endmodule

// File: rtl/sched_base_adjust.sv
module sched_base_adjust
  import baseadj_pkg::*;
#(
  parameter int TIME_W = TIME_W_DEF,
  parameter int CYC_W  = CYC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TIME_W-1:0] base_in,
  input  logic [CYC_W-1:0]  cycle_in,
  input  logic [TIME_W-1:0] now_in,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [TIME_W-1:0] result
);
  localparam int CH_W  = TIME_W + 2;
  localparam int LVL_W = $clog2(CH_W + 1);

  adj_state_t        st;
  logic [CYC_W-1:0]  cyc_q;
  logic [TIME_W-1:0] thr_q, gap_q, run_q, result_q;
  logic [CH_W-1:0]   chunk_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              err_q;

  logic [TIME_W-1:0] thr_w, gap_w, run_w;
  logic              fut_w, zero_w, took_w;

  // named internal events
  logic ev_accept, ev_zero, ev_fast, ev_grow_stop, ev_last_step;

  baseadj_thresh #(.TIME_W(TIME_W), .CYC_W(CYC_W)) u_thr (
    .now_t(now_in), .base_t(base_in), .cyc_t(cycle_in),
    .thr_t(thr_w), .gap_t(gap_w), .in_future(fut_w), .zero_cyc(zero_w));

  baseadj_step #(.TIME_W(TIME_W), .CH_W(CH_W)) u_step (
    .run_v(run_q), .chunk_v(chunk_q), .thr_v(thr_q),
    .run_nxt(run_w), .took(took_w));

  assign ev_accept    = start && (st == S_IDLE);
  assign ev_zero      = ev_accept && zero_w;
  assign ev_fast      = ev_accept && !zero_w && fut_w;
  assign ev_grow_stop = (st == S_GROW) && (chunk_q >= CH_W'(gap_q));
  assign ev_last_step = (st == S_DESC) && (lvl_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cyc_q    <= '0;
      thr_q    <= '0;
      gap_q    <= '0;
      run_q    <= '0;
      chunk_q  <= '0;
      lvl_q    <= '0;
      result_q <= '0;
      err_q    <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (ev_accept) begin
            cyc_q   <= cycle_in;
            thr_q   <= thr_w;
            gap_q   <= gap_w;
            run_q   <= base_in;
            chunk_q <= CH_W'(cycle_in);
            lvl_q   <= '0;
            if (ev_zero) begin
              err_q    <= 1'b1;
              result_q <= base_in;
              st       <= S_DONE;
            end else if (ev_fast) begin
              err_q    <= 1'b0;
              result_q <= base_in;
              st       <= S_DONE;
            end else begin
              err_q <= 1'b0;
              st    <= S_GROW;
            end
          end
        end
        S_GROW: begin
          if (ev_grow_stop) begin
            st <= S_DESC;
          end else begin
            chunk_q <= chunk_q << 1;
            lvl_q   <= lvl_q + 1'b1;
          end
        end
        S_DESC: begin
          run_q <= run_w;
          if (ev_last_step) begin
            result_q <= run_w + TIME_W'(cyc_q);
            st       <= S_DONE;
          end else begin
            chunk_q <= chunk_q >> 1;
            lvl_q   <= lvl_q - 1'b1;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign done   = (st == S_DONE);
  assign err    = err_q;
  assign result = result_q;
endmodule

// File: rtl/sched_base_adjust_chk.sv
module sched_base_adjust_chk #(
  parameter int TIME_W = 64,
  parameter int CYC_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [TIME_W-1:0] base_in,
  input logic [CYC_W-1:0]  cycle_in,
  input logic [TIME_W-1:0] now_in,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [TIME_W-1:0] result,
  input logic              ev_grow_stop,
  input logic              ev_last_step
);
  logic [TIME_W-1:0] cap_base, cap_thr, cap_cyc;
  logic [TIME_W-1:0] in_thr;

  assign in_thr = now_in + (TIME_W'(cycle_in) << 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_base <= '0;
      cap_thr  <= '0;
      cap_cyc  <= '0;
    end else if (start && !busy) begin
      cap_base <= base_in;
      cap_thr  <= in_thr;
      cap_cyc  <= TIME_W'(cycle_in);
    end
  end

  a_r4_zero_error: assert property (@(posedge clk) disable iff (!rst_n)
    done && (cap_cyc == '0) |-> err && (result == cap_base));

  a_r2_future_kept: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (cycle_in != '0) && (base_in >= in_thr)
    |=> done && !err && (result == $past(base_in)));

  a_r1_window: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && (cap_base < cap_thr)
    |-> (result >= cap_thr) && ((result - cap_thr) < cap_cyc));

  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && (cap_cyc != '0) |-> ((result - cap_base) % cap_cyc) == '0);

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(result) && $stable(err));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(result) && $stable(err) && !done);

  a_r3_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grow_stop |=> !done);

  a_r3_last_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_step |=> done);
endmodule

bind sched_base_adjust sched_base_adjust_chk #(.TIME_W(TIME_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_in),
  .cycle_in(cycle_in), .now_in(now_in), .busy(busy), .done(done),
  .err(err), .result(result), .ev_grow_stop(ev_grow_stop),
  .ev_last_step(ev_last_step));

// File: tb/sched_base_adjust_test.sv
module sched_base_adjust_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] base_in = '0;
  logic [31:0] cycle_in = '0;
  logic [63:0] now_in = '0;
  logic        busy, done, err;
  logic [63:0] result;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sched_base_adjust uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_in),
    .cycle_in(cycle_in), .now_in(now_in), .busy(busy), .done(done),
    .err(err), .result(result));

  localparam int NV = 8;
  localparam logic [63:0] V_BASE [NV] = '{
    64'd1000, 64'd0, 64'd9000, 64'd5200, 64'd5199,
    64'h0000_1000_0000_0000, 64'd0, 64'd77};
  localparam logic [63:0] V_NOW [NV] = '{
    64'd5000, 64'd12345, 64'd5000, 64'd5000, 64'd5000,
    64'h0123_4567_89AB_CDEF, 64'd1000, 64'd3_000_000_000};
  localparam logic [31:0] V_CYC [NV] = '{
    32'd100, 32'd7, 32'd100, 32'd100, 32'd100,
    32'hFFFF_FFFF, 32'd1, 32'd1_000_000};

  // expected {err, result}, written with plain division
  function automatic logic [64:0] ref_adjust(input logic [63:0] b, input logic [63:0] n,
                                             input logic [31:0] c);
    logic [63:0] t, k, c64;
    if (c == 0) return {1'b1, b};
    c64 = {32'd0, c};
    t = n + 2 * c64;
    if (b >= t) return {1'b0, b};
    k = (t - b + c64 - 1) / c64;
    return {1'b0, b + k * c64};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] b, input logic [63:0] n, input logic [31:0] c,
                        output int lat);
    base_in = b; now_in = n; cycle_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    if (!done) chk(1'b0, "R5 done timeout", 64'(lat), 64'd400);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [64:0] e;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(!busy && !done && !err, "R7 reset flags", {61'd0, busy, done, err}, 64'd0);
    chk(result == 0, "R7 reset result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      e = ref_adjust(V_BASE[i], V_NOW[i], V_CYC[i]);
      run_op(V_BASE[i], V_NOW[i], V_CYC[i], lat);
      chk(result == e[63:0], "R1/R3 result", result, e[63:0]);
      chk(err == e[64], "R3 err", {63'd0, err}, {63'd0, e[64]});
      if (V_BASE[i] >= V_NOW[i] + 2 * {32'd0, V_CYC[i]})
        chk(lat == 0, "R2 fast latency", 64'(lat), 64'd0);
      held = result;
      @(negedge clk);
      chk(!done, "R5 done one clock", {63'd0, done}, 64'd0);
      chk(result == held, "R5 result held", result, held);
    end

    // R1 window on first vector: 5200 is exactly threshold
    run_op(64'd1000, 64'd5000, 32'd100, lat);
    chk(result == 64'd5200, "R1 lands on threshold", result, 64'd5200);
    @(negedge clk);

    // R4 zero cycle overlapping the pass-through case: error wins
    run_op(64'd6000, 64'd5000, 32'd0, lat);
    chk(err == 1'b1, "R4 err set", {63'd0, err}, 64'd1);
    chk(result == 64'd6000, "R4 result is base", result, 64'd6000);
    chk(lat == 0, "R4 latency", 64'(lat), 64'd0);
    @(negedge clk);
    run_op(64'd5199, 64'd5000, 32'd100, lat);
    chk(err == 1'b0 && result == 64'd5299, "R3 one cycle step, err cleared", result, 64'd5299);
    @(negedge clk);

    // R6 start while busy is ignored
    base_in = 64'd1000; now_in = 64'd5000; cycle_in = 32'd100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R6 busy mid job", {63'd0, busy}, 64'd1);
    base_in = 64'd9000; cycle_in = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    chk(result == 64'd5200 && !err, "R6 mid-job start ignored", result, 64'd5200);
    // start in the done clock
    base_in = 64'd42; cycle_in = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !busy, "R6 done-clock start no job", {62'd0, done, busy}, 64'd0);
    repeat (3) @(negedge clk);
    chk(result == 64'd5200 && !err && !done, "R6 result kept after done-clock start",
        result, 64'd5200);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule